// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (256 x 8)

This block models a 256-byte serial EEPROM that sits on a two-wire bus as a slave. It samples the bus clock and data lines with the system clock and detects start and stop conditions. It answers only to a device address byte whose upper nibble is the fixed value 1010 and whose next three bits equal the three strap inputs. It pulls the data line low through an open-drain enable to acknowledge and to return read data.

A write carries a word address byte followed by zero or more data bytes. Data bytes are held in an 8-byte page buffer. The buffer is written into the storage array at the stop condition. The stop also starts an internal write cycle of a fixed number of system clocks, and during that cycle the device answers no address. A master finds out when the cycle has ended by polling with start plus device address until it gets an acknowledge.

A read returns the byte at the internal address counter and advances that counter. The master can keep the read going with acknowledges. A random read is a write with only a word address, followed by a repeated start and a read.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The device acknowledges (SDA low in the ninth bit) only a device address byte whose bits 7:4 are 1010 and whose bits 3:1 equal `strap_i`. On any other byte it leaves SDA released and ignores all later bytes until the next start condition.
- R2: In a write, the device acknowledges the word address byte and every data byte. After the stop, each data byte can be read back from its address.
- R3: In a write, each data byte goes to the current address, after which only address bits 2:0 increment. Bits 7:3 stay fixed, so the ninth byte of a transfer overwrites the first byte's location.
- R4: A stop that follows at least one data byte starts an internal write cycle. While that cycle runs, a device address byte is not acknowledged.
- R5: Once `WRITE_CLKS` system clocks have passed after that stop, the device acknowledges its address again.
- R6: A read without a preceding word address (current-address read) returns the byte at the last accessed address plus one.
- R7: In a read, a master acknowledge (SDA low) after a byte makes the device send the byte at the next address. The address wraps from 0xFF to 0x00.
- R8: A master not-acknowledge (SDA high) after a read byte ends the read, and the device keeps SDA released afterwards.
- R9: A write that carries a word address and no data byte, ended by a stop or a repeated start, does not start a write cycle. It sets the address that the next read uses.
- R10: Bit 0 of the device address byte picks the direction: 1 starts a read in which the device drives data, 0 starts a write in which the device expects a word address.
- R11: After reset the device does not drive SDA and waits in standby for a start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Hard-wired device select bits compared with address bits 3:1 |
| sda_oe_o | output | 1 | When high, the device pulls the data line low |

## Verification
The hardest condition to reach is the in-page wraparound combined with a late commit. The stimulus writes nine bytes starting two slots before the end of a page, waits out the write cycle by polling, and then reads the whole page back in one sequential burst. From the burst it can tell where the overwrite landed and that the next page was left alone. The busy window is reached by polling right after the stop. The first poll has to be refused, and the number of polls needed is bounded by the write-cycle length. The address rollover from 0xFF to 0x00 is reached with a random read two bytes below the top of the array.

// File: rtl/eeprom_pkg.sv
// Shared definitions for the serial EEPROM slave.
// Assumes an 8-bit byte on the bus and a one-byte word address.
package eeprom_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    // Protocol phases of the slave
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_WORDADDR,
        ST_WRDATA,
        ST_ACK,
        ST_RDDATA,
        ST_RDACK
    } bus_state_t;

endpackage

// File: rtl/bus_sampler.sv
// Brings SCL and SDA into the clock domain and flags clock edges and
// start/stop conditions. Assumes bus edges are slower than a few clocks.
module bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic scl_prev, sda_prev;
    logic scl_s;

    // Synchronizer chains, reset to the idle bus level
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_i;
                    sda_sync <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    // One-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Edge and condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/write_timer.sv
// Counts out the internal write cycle. Assumes launch is a one-cycle pulse.
module write_timer #(
    parameter int WRITE_CLKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);

    localparam int CYC_W = $clog2(WRITE_CLKS + 1);
    localparam logic [CYC_W-1:0] CYC_LOAD = CYC_W'(WRITE_CLKS);

    logic [CYC_W-1:0] remain;

    // Down-counter loaded at launch, idles at zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (launch)
            remain <= CYC_LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R4
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

endmodule

// File: rtl/page_store.sv
// Storage array plus one page of write buffer. Data bytes land in the
// buffer by slot and are copied into the array on commit.
// Assumes row_set, wr_en and commit never coincide.
module page_store #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       row_set,
    input  logic [ADDR_W-PAGE_W-1:0]   row_in,
    input  logic                       wr_en,
    input  logic [PAGE_W-1:0]          wr_slot,
    input  logic [eeprom_pkg::BYTE_W-1:0] wr_data,
    input  logic                       commit,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [eeprom_pkg::BYTE_W-1:0] rd_data
);
    import eeprom_pkg::*;

    localparam int ROW_W = ADDR_W - PAGE_W;
    localparam int SLOTS = 1 << PAGE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem   [DEPTH];
    logic [BYTE_W-1:0] buf_q [SLOTS];
    logic [SLOTS-1:0]  valid;
    logic [ROW_W-1:0]  row_q;

    // Page buffer: row latch, slot data and slot valid flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            row_q <= '0;
        end else if (row_set) begin
            valid <= '0;
            row_q <= row_in;
        end else if (wr_en) begin
            valid[wr_slot] <= 1'b1;
        end else if (commit) begin
            valid <= '0;
        end
    end

    // Buffer data slots (no reset needed, qualified by valid)
    always_ff @(posedge clk) begin
        if (wr_en)
            buf_q[wr_slot] <= wr_data;
    end

    // Copy every filled slot into the array on commit
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (valid[i])
                    mem[{row_q, PAGE_W'(i)}] <= buf_q[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    // R2
    commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (valid == '0));

endmodule

// File: rtl/i2c_eeprom_slave.sv
// Two-wire serial EEPROM slave, 256 x 8. Decodes the device address against
// the straps, runs write and read transfers, buffers page data, and blocks
// its address during the internal write cycle. Assumes SCL stays in each
// level for several system clocks.
module i2c_eeprom_slave #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int WRITE_CLKS  = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);
    import eeprom_pkg::*;

    localparam int ROW_W = ADDR_W - PAGE_W;
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [3:0] BITS_FULL = 4'd8;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, launch, row_set, buf_we, rx_done, dev_match;
    bus_state_t state, after_ack;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] rd_data;
    logic [3:0]        bitcnt;
    logic [ADDR_W-1:0] addr_ptr;
    logic              master_ack;
    logic              pending;
    logic              oe;

    bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    write_timer #(.WRITE_CLKS(WRITE_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy)
    );

    page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .row_set(row_set), .row_in(shreg[ADDR_W-1:PAGE_W]),
        .wr_en(buf_we), .wr_slot(addr_ptr[PAGE_W-1:0]), .wr_data(shreg),
        .commit(launch), .rd_addr(addr_ptr), .rd_data(rd_data)
    );

    // Event decode shared by the FSM and the store strobes
    always_comb begin
        rx_done   = scl_fall && (bitcnt == BITS_FULL);
        dev_match = (shreg[7:4] == DEV_PREFIX) && (shreg[3:1] == strap_i) && !busy;
        launch    = stop_det && pending;
        row_set   = !start_det && !stop_det && (state == ST_WORDADDR) && rx_done;
        buf_we    = !start_det && !stop_det && (state == ST_WRDATA) && rx_done;
    end

    // Protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            after_ack  <= ST_IDLE;
            shreg      <= '0;
            bitcnt     <= '0;
            addr_ptr   <= '0;
            master_ack <= 1'b0;
            pending    <= 1'b0;
            oe         <= 1'b0;
        end else if (start_det) begin
            state  <= ST_DEVADDR;
            bitcnt <= '0;
            oe     <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            oe      <= 1'b0;
            pending <= 1'b0;
        end else begin
            case (state)
                ST_DEVADDR, ST_WORDADDR, ST_WRDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (rx_done) begin
                        bitcnt <= '0;
                        if (state == ST_DEVADDR) begin
                            if (dev_match) begin
                                oe        <= 1'b1;
                                state     <= ST_ACK;
                                after_ack <= shreg[0] ? ST_RDDATA : ST_WORDADDR;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WORDADDR) begin
                            addr_ptr  <= shreg[ADDR_W-1:0];
                            oe        <= 1'b1;
                            state     <= ST_ACK;
                            after_ack <= ST_WRDATA;
                        end else begin
                            addr_ptr  <= {addr_ptr[ADDR_W-1:PAGE_W],
                                          addr_ptr[PAGE_W-1:0] + 1'b1};
                            pending   <= 1'b1;
                            oe        <= 1'b1;
                            state     <= ST_ACK;
                            after_ack <= ST_WRDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (after_ack == ST_RDDATA) begin
                            shreg    <= rd_data;
                            oe       <= ~rd_data[BYTE_W-1];
                            bitcnt   <= 4'd1;
                            addr_ptr <= addr_ptr + ADDR_ONE;
                            state    <= ST_RDDATA;
                        end else begin
                            oe     <= 1'b0;
                            bitcnt <= '0;
                            state  <= after_ack;
                        end
                    end
                end
                ST_RDDATA: begin
                    if (scl_fall) begin
                        if (bitcnt == BITS_FULL) begin
                            oe    <= 1'b0;
                            state <= ST_RDACK;
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            oe     <= ~shreg[BYTE_W-2];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            shreg    <= rd_data;
                            oe       <= ~rd_data[BYTE_W-1];
                            bitcnt   <= 4'd1;
                            addr_ptr <= addr_ptr + ADDR_ONE;
                            state    <= ST_RDDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    oe <= 1'b0;
                end
            endcase
        end
    end

    assign sda_oe_o = oe;

    // R11
    oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (state == ST_ACK || state == ST_RDDATA));

    // R4
    busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEVADDR && rx_done && busy && !start_det && !stop_det)
        |=> (!sda_oe_o && state == ST_IDLE));

    // R9
    nodata_nolaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !pending && !busy) |=> !busy);

    // R3
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> (addr_ptr[ADDR_W-1:PAGE_W] == $past(addr_ptr[ADDR_W-1:PAGE_W])));

    // R8
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDACK && scl_fall && !master_ack) |=> (!sda_oe_o && state == ST_IDLE));

endmodule

// File: tb/i2c_eeprom_slave_test.sv
// Scoreboard bench: master tasks push expected values, a monitor pops and
// compares them against what the bus returns.
module i2c_eeprom_slave_test;

    localparam int Q     = 12;
    localparam int WCLK  = 600;
    localparam logic [7:0] DEV_W = 8'hAA;
    localparam logic [7:0] DEV_R = 8'hAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [2:0] strap = 3'b101;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_eeprom_slave #(.WRITE_CLKS(WCLK)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .strap_i(strap), .sda_oe_o(sda_oe)
    );

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    event obs_ev;
    int   obs_val;

    // Monitor: pop the oldest expectation and compare
    always @(obs_ev) begin
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL %s unexpected result actual=%0h expected=none", "R?", obs_val);
        end else begin
            e = exp_q.pop_front();
            if (e.val != obs_val) begin
                failures++;
                $display("FAIL %s actual=%0h expected=%0h", e.tag, obs_val, e.val);
            end
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_v(input int v, input string tag);
        exp_q.push_back('{v, tag});
    endtask

    task automatic observe(input int v);
        obs_val = v;
        ->obs_ev;
        #1;
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        m_sda = b;
        wq(Q);
        m_scl = 1'b1;
        wq(Q);
        r = sda_line;
        wq(Q);
        m_scl = 1'b0;
        wq(Q);
    endtask

    task automatic start_c();
        m_sda = 1'b1;
        wq(Q);
        m_scl = 1'b1;
        wq(Q);
        m_sda = 1'b0;
        wq(Q);
        m_scl = 1'b0;
        wq(Q);
    endtask

    task automatic stop_c();
        m_sda = 1'b0;
        wq(Q);
        m_scl = 1'b1;
        wq(Q);
        m_sda = 1'b1;
        wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ackbit);
        logic r;
        for (int i = 7; i >= 0; i--) bit_xfer(v[i], r);
        bit_xfer(1'b1, ackbit);
    endtask

    // Send a byte and score the acknowledge level (0 = acknowledged)
    task automatic tx(input logic [7:0] v, input int exp_ack, input string tag);
        logic a;
        expect_v(exp_ack, tag);
        send_byte(v, a);
        observe(int'(a));
    endtask

    // Read a byte, answer with ack (1) or nack (0), and score the data
    task automatic rx(input logic [7:0] exp_byte, input bit more, input string tag);
        logic [7:0] d;
        logic r;
        expect_v(int'(exp_byte), tag);
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, r);
            d[i] = r;
        end
        bit_xfer(more ? 1'b0 : 1'b1, r);
        observe(int'(d));
    endtask

    // Poll with write-direction address until acknowledged; leaves bus owned
    task automatic wait_ready(output int polls);
        logic a;
        polls = 0;
        for (int k = 0; k < 40; k++) begin
            start_c();
            send_byte(DEV_W, a);
            polls++;
            if (a == 1'b0) break;
            stop_c();
        end
    endtask

    initial begin
        int polls;
        wq(5);
        rst_n = 1'b1;
        wq(4);

        // R11: released after reset
        expect_v(0, "R11");
        observe(int'(sda_oe));

        // R1: wrong straps, then ignored until a start
        start_c();
        tx(8'hA0 | (8'(3'b011) << 1), 1, "R1");
        tx(DEV_W, 1, "R1");
        stop_c();
        start_c();
        tx(8'hB0 | (8'(strap) << 1), 1, "R1");
        stop_c();

        // R2, R10: write two bytes at 0x10
        start_c();
        tx(DEV_W, 0, "R1");
        tx(8'h10, 0, "R2");
        tx(8'h5C, 0, "R2");
        tx(8'hA7, 0, "R2");
        stop_c();

        // R4: immediate poll refused
        start_c();
        tx(DEV_W, 1, "R4");
        stop_c();
        // R5: ready again within a bounded number of polls
        wait_ready(polls);
        expect_v(1, "R5");
        observe(int'(polls <= 3));
        // continue as dummy write: random read at 0x10 (R9)
        tx(8'h10, 0, "R9");
        start_c();
        tx(DEV_R, 0, "R10");
        rx(8'h5C, 1'b0, "R2");
        stop_c();

        // R6: current address read gives 0x11
        start_c();
        tx(DEV_R, 0, "R6");
        rx(8'hA7, 1'b0, "R6");
        stop_c();

        // R9: dummy write with stop does not start a write cycle
        start_c();
        tx(DEV_W, 0, "R9");
        tx(8'h10, 0, "R9");
        stop_c();
        start_c();
        tx(DEV_W, 0, "R9");
        stop_c();

        // R3: nine bytes from 0x2E wrap inside page 0x28
        start_c();
        tx(DEV_W, 0, "R3");
        tx(8'h2E, 0, "R3");
        for (int i = 0; i < 9; i++) tx(8'h40 + 8'(i * 7), 0, "R3");
        stop_c();
        wait_ready(polls);
        tx(8'h28, 0, "R3");
        start_c();
        tx(DEV_R, 0, "R3");
        for (int k = 0; k < 6; k++) rx(8'h40 + 8'((k + 2) * 7), 1'b1, "R3");
        rx(8'h40 + 8'(8 * 7), 1'b1, "R3");
        rx(8'h40 + 8'(1 * 7), 1'b0, "R3");
        stop_c();

        // R7: fill top page and address zero, then read across the top
        start_c();
        tx(DEV_W, 0, "R7");
        tx(8'hF8, 0, "R7");
        for (int i = 0; i < 8; i++) tx(8'hC0 + 8'(i), 0, "R7");
        stop_c();
        wait_ready(polls);
        tx(8'h00, 0, "R7");
        tx(8'h3D, 0, "R7");
        stop_c();
        wait_ready(polls);
        tx(8'hFE, 0, "R7");
        start_c();
        tx(DEV_R, 0, "R7");
        rx(8'hC6, 1'b1, "R7");
        rx(8'hC7, 1'b1, "R7");
        rx(8'h3D, 1'b0, "R7");

        // R8: after the nack the line stays high
        m_sda = 1'b1;
        wq(2 * Q);
        expect_v(1, "R8");
        observe(int'(sda_line));
        m_scl = 1'b1;
        wq(Q);
        expect_v(1, "R8");
        observe(int'(sda_line));
        m_scl = 1'b0;
        wq(Q);
        stop_c();

        wq(4);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R? actual=%0d expected=0 leftover expectations", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule